// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the single even-parity bit that covers a 32-bit multiplexed address/data bus together with its 4-bit command/byte-enable lanes. On every bus phase it works out from the phase kind (address, data, turnaround or idle), the agent's role (initiator or target) and the transfer direction whether the local agent owns the parity line in the next clock or must check the value another agent puts there.

The parity for a phase appears one clock after the address/data and command/byte-enable values it covers. When the block owns the parity line it drives the computed bit and raises an output enable. When it checks, it samples the incoming parity bit in that following clock and compares it with its own calculation. A mismatch gives a one-clock error pulse that is registered on the clock edge where the incoming bit was sampled. The bus sequencer that produces the phase qualifiers, and any error-pin signalling policy beyond that pulse, sit outside this block.

Top module: `pcipar_unit`

## Requirements
- R1: When the parity output enable is high, `par_o` makes the 37 bits {ad, cbe, par} of the phase one clock earlier hold an even number of ones.
- R2: In the initiator role (`role_i`=1), an address phase (`phase_i`=2'b01) and a write data phase (`phase_i`=2'b10, `write_i`=1) each raise `par_oe_o` in the next clock.
- R3: In the target role (`role_i`=0), a read data phase (`phase_i`=2'b10, `write_i`=0) raises `par_oe_o` in the next clock.
- R4: The block checks parity on an initiator read data phase, and on a target address phase or target write data phase. It does not raise `par_oe_o` for any of these phases.
- R5: A turnaround phase (`phase_i`=2'b11), an idle phase (`phase_i`=2'b00) and any cycle with `valid_i` low neither drive nor check parity: `par_oe_o` stays low in the next clock and no error can follow.
- R6: `par_o` and `par_oe_o` for a phase are valid in exactly the one clock after that phase. The enable falls in the clock after a phase that is not driven.
- R7: For a checked phase, `perr_o` is high for exactly the one clock after the clock in which `par_i` was sampled if `par_i` differs from the computed parity. It stays low if they match, and it stays low after any phase that is not checked.
- R8: While reset is applied, `par_oe_o`, `par_o` and `perr_o` are low. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R9: The command/byte-enable bits count toward parity. With ad all zero and cbe=4'b0001, the driven parity is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A bus phase is present this clock |
| phase_i | input | 2 | Phase kind: 00 idle, 01 address, 10 data, 11 turnaround |
| role_i | input | 1 | 1 = local agent is initiator, 0 = target |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| ad_i | input | 32 | Address/data bus value of this phase |
| cbe_i | input | 4 | Command (address phase) or byte enables (data phase) |
| par_i | input | 1 | Parity line sampled from the bus, one clock after its phase |
| par_o | output | 1 | Computed parity for the previous phase |
| par_oe_o | output | 1 | Drive enable for the parity line |
| perr_o | output | 1 | One-clock parity-error pulse |

## Verification
The hardest case to reach is a checked phase followed directly by another checked phase, where only the second phase's incoming parity is corrupted. The error pulse then has to come from the right phase, and no pulse may carry over. The stimulus reaches this with back-to-back random phases over every role, direction and phase code, and corrupts the sampled parity bit on about a quarter of the clocks, independently of the next phase. Directed sequences add read turnarounds, isolated command-only parity and a long run of mismatches.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10,
    PH_TURN = 2'b11
  } phase_e;

  typedef struct packed {
    logic drive;
    logic check;
  } duty_t;
endpackage

// File: rtl/pcipar_duty.sv
module pcipar_duty
  import pcipar_pkg::*;
(
  input  logic   valid_i,
  input  phase_e phase_i,
  input  logic   role_i,
  input  logic   write_i,
  output duty_t  duty_o
);
  logic owns_data;

  // Data ownership: initiator on writes, target on reads.
  assign owns_data = (role_i == write_i);

  always_comb begin
    duty_o = '0;
    if (valid_i) begin
      unique case (phase_i)
        PH_ADDR: begin
          duty_o.drive = role_i;
          duty_o.check = ~role_i;
        end
        PH_DATA: begin
          duty_o.drive = owns_data;
          duty_o.check = ~owns_data;
        end
        default: duty_o = '0;
      endcase
    end
  end

  always_comb begin
    if (valid_i && (phase_i == PH_ADDR || phase_i == PH_DATA))
      p_one_duty_r4: assert ($countones({duty_o.drive, duty_o.check}) == 1);
  end
endmodule

// File: rtl/pcipar_tree.sv
module pcipar_tree #(
  parameter int W     = 36,
  parameter int CHUNK = 8
) (
  input  logic [W-1:0] vec_i,
  output logic         par_o
);
  localparam int PARTS = (W + CHUNK - 1) / CHUNK;

  logic [PARTS-1:0] part;

  for (genvar g = 0; g < PARTS; g++) begin : g_leaf
    localparam int LO = g * CHUNK;
    localparam int HI = ((LO + CHUNK) < W) ? (LO + CHUNK - 1) : (W - 1);
    assign part[g] = ^vec_i[HI:LO];
  end

  assign par_o = ^part;
endmodule

// File: rtl/pcipar_stage.sv
module pcipar_stage
  import pcipar_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  valid_i,
  input  logic  par_calc_i,
  input  duty_t duty_i,
  output logic  par_q_o,
  output duty_t duty_q_o
);
  logic  par_d;
  duty_t duty_d;

  always_comb begin
    par_d  = par_q_o;
    duty_d = duty_i;
    if (valid_i) par_d = par_calc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q_o  <= 1'b0;
      duty_q_o <= '0;
    end else begin
      par_q_o  <= par_d;
      duty_q_o <= duty_d;
    end
  end

  p_oe_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_i.drive |=> !duty_q_o.drive);
endmodule

// File: rtl/pcipar_judge.sv
module pcipar_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic check_q_i,
  input  logic par_q_i,
  input  logic par_in_i,
  output logic perr_o
);
  logic perr_d;

  always_comb begin
    perr_d = 1'b0;
    if (check_q_i) perr_d = (par_in_i != par_q_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perr_o <= 1'b0;
    else        perr_o <= perr_d;
  end

  p_err_needs_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !check_q_i |=> !perr_o);
  p_err_on_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (check_q_i && (par_in_i != par_q_i)) |=> perr_o);
endmodule

// File: rtl/pcipar_unit.sv
module pcipar_unit
  import pcipar_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [1:0]       phase_i,
  input  logic             role_i,
  input  logic             write_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_o
);
  localparam int COVER_W = AD_W + CBE_W;

  logic [1:0] rst_pipe;
  logic       rst_s_n;
  phase_e     phase;
  duty_t      duty, duty_q;
  logic       par_calc, par_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign phase = phase_e'(phase_i);

  pcipar_duty u_duty (
    .valid_i (valid_i),
    .phase_i (phase),
    .role_i  (role_i),
    .write_i (write_i),
    .duty_o  (duty)
  );

  pcipar_tree #(.W(COVER_W), .CHUNK(CHUNK)) u_tree (
    .vec_i ({ad_i, cbe_i}),
    .par_o (par_calc)
  );

  pcipar_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .valid_i    (valid_i),
    .par_calc_i (par_calc),
    .duty_i     (duty),
    .par_q_o    (par_q),
    .duty_q_o   (duty_q)
  );

  pcipar_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .check_q_i (duty_q.check),
    .par_q_i   (par_q),
    .par_in_i  (par_i),
    .perr_o    (perr_o)
  );

  assign par_o    = par_oe_o ? par_q : 1'b0;
  assign par_oe_o = duty_q.drive;

  p_even_cover_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    par_oe_o |-> ((^{$past(ad_i), $past(cbe_i)}) == par_o));
  p_init_drive_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_i && role_i && (phase_i == 2'b01 || (phase_i == 2'b10 && write_i)))
      |=> par_oe_o);
  p_tgt_drive_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_i && !role_i && phase_i == 2'b10 && !write_i) |=> par_oe_o);
  p_quiet_phase_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!valid_i || phase_i == 2'b00 || phase_i == 2'b11) |=> !par_oe_o);

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r8: assert (!par_oe_o && !perr_o && !par_o);
  end
endmodule

// File: tb/pcipar_unit_bench.sv
module pcipar_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  phase_i;
  logic        role_i, write_i, par_i;
  logic [31:0] ad_i;
  logic [3:0]  cbe_i;
  logic        par_o, par_oe_o, perr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic     p_drive, p_check, p_par, q_perr;
  string    p_tag;

  always #5 clk = ~clk;

  pcipar_unit u_pcipar_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .phase_i(phase_i),
    .role_i(role_i), .write_i(write_i), .ad_i(ad_i), .cbe_i(cbe_i),
    .par_i(par_i), .par_o(par_o), .par_oe_o(par_oe_o), .perr_o(perr_o)
  );

  function automatic logic f_drive(logic v, logic [1:0] ph, logic ro, logic wr);
    if (!v) return 1'b0;
    if (ph == 2'b01) return ro;
    if (ph == 2'b10) return (ro == wr);
    return 1'b0;
  endfunction

  function automatic logic f_check(logic v, logic [1:0] ph, logic ro, logic wr);
    if (!v) return 1'b0;
    if (ph == 2'b01) return !ro;
    if (ph == 2'b10) return (ro != wr);
    return 1'b0;
  endfunction

  function automatic string f_tag(logic v, logic [1:0] ph, logic ro, logic wr);
    if (!v || ph == 2'b00 || ph == 2'b11) return "R5";
    if (ph == 2'b01) return ro ? "R2" : "R4";
    if (ro && wr)    return "R2";
    if (!ro && !wr)  return "R3";
    return "R4";
  endfunction

  task automatic chk(logic act, logic exp, string req, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic run(logic v, logic [1:0] ph, logic ro, logic wr,
                     logic [31:0] ad, logic [3:0] cbe, logic err);
    logic new_perr;
    @(posedge clk); #1;
    valid_i = v; phase_i = ph; role_i = ro; write_i = wr;
    ad_i = ad; cbe_i = cbe;
    par_i = p_par ^ err;
    new_perr = p_check && err;
    @(negedge clk);
    chk(par_oe_o, p_drive, p_tag, "par_oe_o");
    if (p_drive) chk(par_o, p_par, "R1", "par_o");
    chk(perr_o, q_perr, "R7", "perr_o");
    q_perr  = new_perr;
    p_drive = f_drive(v, ph, ro, wr);
    p_check = f_check(v, ph, ro, wr);
    p_par   = ^{ad, cbe};
    p_tag   = f_tag(v, ph, ro, wr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; valid_i = 0; phase_i = 0; role_i = 0; write_i = 0;
    ad_i = 0; cbe_i = 0; par_i = 0;
    p_drive = 0; p_check = 0; p_par = 0; q_perr = 0; p_tag = "R5";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(par_oe_o, 1'b0, "R8", "reset par_oe_o");
    chk(perr_o,   1'b0, "R8", "reset perr_o");
    chk(par_o,    1'b0, "R8", "reset par_o");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9: command bits alone set parity
    run(1, 2'b01, 1, 0, 32'h0, 4'b0001, 0);
    run(0, 2'b00, 0, 0, 32'h0, 4'b0000, 0);
    chk(par_o, 1'b1, "R9", "cbe-only parity");
    chk(par_oe_o, 1'b1, "R6", "oe one clock after address");
    run(0, 2'b00, 0, 0, 32'h0, 4'b0000, 0);
    chk(par_oe_o, 1'b0, "R6", "oe falls after idle");

    // Target read: address checked, turnaround quiet, data driven
    run(1, 2'b01, 0, 0, 32'h1234_5678, 4'b0110, 0);
    run(1, 2'b11, 0, 0, 32'hFFFF_FFFF, 4'hF, 1);
    run(1, 2'b10, 0, 0, 32'hA5A5_0001, 4'b0000, 1);
    run(1, 2'b10, 0, 0, 32'h0000_0003, 4'b1110, 0);
    run(0, 2'b00, 0, 0, 32'h0, 4'h0, 0);

    // Initiator read with bad parity on consecutive data phases (R4, R7)
    run(1, 2'b01, 1, 0, 32'hDEAD_BEEF, 4'b0110, 0);
    run(1, 2'b11, 1, 0, 32'h0, 4'h0, 0);
    run(1, 2'b10, 1, 0, 32'h0000_0001, 4'h0, 0);
    run(1, 2'b10, 1, 0, 32'h0000_0007, 4'h1, 1);
    run(1, 2'b10, 1, 0, 32'h8000_0000, 4'h3, 1);
    run(0, 2'b00, 1, 0, 32'h0, 4'h0, 1);
    run(0, 2'b00, 1, 0, 32'h0, 4'h0, 1);

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      run(($urandom % 8) != 0, 2'($urandom), 1'($urandom), 1'($urandom),
          $urandom, 4'($urandom), ($urandom % 4) == 0);
    end
    run(0, 2'b00, 0, 0, 32'h0, 4'h0, 0);
    run(0, 2'b00, 0, 0, 32'h0, 4'h0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule